// File: doc/BRIEF.md
# Subset Instruction Control Decoder

This block turns one 32-bit instruction word into the control lines, ALU operation, register specifiers and sign-extended immediates that a single-cycle datapath needs. It covers nine instructions: four register-to-register operations (add, subtract, bitwise AND, bitwise OR), a load, a store, compare-and-branch-on-zero, an unconditional branch and a halt. It is purely combinational; the datapath places it between instruction fetch and the register read.

Opcodes come in three lengths. The register and memory instructions and the halt are matched on bits 31:21. The compare-and-branch is matched on bits 31:24. The unconditional branch is matched on bits 31:26. The 11-bit match is tried first, then the 8-bit one, then the 6-bit one. A word that matches nothing yields all control lines low, the add code and halt low. Such a word therefore changes no architectural state.

Top module: `subset_decoder`

## Requirements
- R1: Bits 31:21 equal to 10001011000 (add), 11001011000 (subtract), 10001010000 (AND) or 10101010000 (OR) give reg_we=1 and alu_op 2, 6, 0 or 1 respectively. All other control outputs and halt are 0.
- R2: Bits 31:21 equal to 11111000010 (load) give alu_op=2 with mem_re, wb_from_mem, alu_use_imm and reg_we at 1. All other control outputs and halt are 0.
- R3: Bits 31:21 equal to 11111000000 (store) give alu_op=2 with mem_we, alu_use_imm and rd2_from_dest at 1. All other control outputs, reg_we included, and halt are 0.
- R4: When no 11-bit opcode matches and bits 31:24 equal 10110100 (compare-and-branch-on-zero), the outputs are alu_op=7 (pass operand B), rd2_from_dest=1 and br_cond=1. All other control outputs and halt are 0.
- R5: When neither longer opcode matches and bits 31:26 equal 000101 (branch), the outputs are br_always=1 and alu_op=2. All other control outputs and halt are 0.
- R6: Bits 31:21 equal to 11010100010 give halt=1 with every control line 0 and alu_op=2. Halt is 0 for every other word.
- R7: A word that matches no opcode gives all control lines 0, alu_op=2 and halt 0.
- R8: For every word, rs_a equals bits 9:5, rs_b equals bits 20:16 and rd_t equals bits 4:0.
- R9: imm_mem is bits 20:12, sign-extended to 32 bits from bit 20.
- R10: imm_cbr is bits 23:5, sign-extended to 32 bits from bit 23.
- R11: imm_jmp is bits 25:0, sign-extended to 32 bits from bit 25.
- R12: For every word, at most one of mem_re, mem_we, br_cond, br_always and halt is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| rd2_from_dest | output | 1 | Second register read takes bits 4:0 instead of bits 20:16 |
| alu_use_imm | output | 1 | ALU operand B takes the memory offset |
| wb_from_mem | output | 1 | Register write data comes from memory |
| reg_we | output | 1 | Register file write enable |
| mem_re | output | 1 | Data memory read |
| mem_we | output | 1 | Data memory write |
| br_cond | output | 1 | Branch taken if ALU result is zero |
| br_always | output | 1 | Unconditional branch |
| halt | output | 1 | Halt instruction decoded |
| alu_op | output | 4 | ALU operation: 0 AND, 1 OR, 2 add, 6 subtract, 7 pass B |
| rs_a | output | 5 | First read register, bits 9:5 |
| rs_b | output | 5 | Second register, bits 20:16 |
| rd_t | output | 5 | Destination or transfer register, bits 4:0 |
| imm_mem | output | 32 | Sign-extended load/store offset |
| imm_cbr | output | 32 | Sign-extended compare-and-branch offset |
| imm_jmp | output | 32 | Sign-extended branch offset |

## Verification
The bench walks all 2048 values of bits 31:21. Each value is paired with pseudo-random lower bits. This shows that every 11-bit opcode, every 8-bit and 6-bit prefix, and every unmatched word lands in the right class. It also shows that the lower bits never change the class. A second sweep steps the 9-bit load/store offset through all 512 values. Further walks set the sign bits of the 19-bit and 26-bit offsets both ways. These sweeps separate correct sign extension from zero extension or from a wrong sign position.

// File: rtl/subset_decoder.sv
module subset_decoder #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic [31:0]   insn,
  output logic          rd2_from_dest,
  output logic          alu_use_imm,
  output logic          wb_from_mem,
  output logic          reg_we,
  output logic          mem_re,
  output logic          mem_we,
  output logic          br_cond,
  output logic          br_always,
  output logic          halt,
  output logic [AW-1:0] alu_op,
  output logic [4:0]    rs_a,
  output logic [4:0]    rs_b,
  output logic [4:0]    rd_t,
  output logic [DW-1:0] imm_mem,
  output logic [DW-1:0] imm_cbr,
  output logic [DW-1:0] imm_jmp
);
  localparam logic [10:0] OP_ADD = 11'b10001011000;
  localparam logic [10:0] OP_SUB = 11'b11001011000;
  localparam logic [10:0] OP_AND = 11'b10001010000;
  localparam logic [10:0] OP_ORR = 11'b10101010000;
  localparam logic [10:0] OP_LD  = 11'b11111000010;
  localparam logic [10:0] OP_ST  = 11'b11111000000;
  localparam logic [10:0] OP_HLT = 11'b11010100010;
  localparam logic [7:0]  OP_CBZ = 8'b10110100;
  localparam logic [5:0]  OP_BR  = 6'b000101;

  localparam logic [AW-1:0] ALU_AND = AW'(0);
  localparam logic [AW-1:0] ALU_OR  = AW'(1);
  localparam logic [AW-1:0] ALU_ADD = AW'(2);
  localparam logic [AW-1:0] ALU_SUB = AW'(6);
  localparam logic [AW-1:0] ALU_PB  = AW'(7);

  localparam int MEM_W = 9;
  localparam int CBR_W = 19;
  localparam int JMP_W = 26;

  assign rs_a = insn[9:5];
  assign rs_b = insn[20:16];
  assign rd_t = insn[4:0];

  assign imm_mem = {{(DW-MEM_W){insn[20]}}, insn[20:12]};
  assign imm_cbr = {{(DW-CBR_W){insn[23]}}, insn[23:5]};
  assign imm_jmp = {{(DW-JMP_W){insn[25]}}, insn[25:0]};

  always_comb begin
    rd2_from_dest = 1'b0;
    alu_use_imm   = 1'b0;
    wb_from_mem   = 1'b0;
    reg_we        = 1'b0;
    mem_re        = 1'b0;
    mem_we        = 1'b0;
    br_cond       = 1'b0;
    br_always     = 1'b0;
    halt          = 1'b0;
    alu_op        = ALU_ADD;
    case (insn[31:21])
      OP_ADD: begin reg_we = 1'b1; alu_op = ALU_ADD; end
      OP_SUB: begin reg_we = 1'b1; alu_op = ALU_SUB; end
      OP_AND: begin reg_we = 1'b1; alu_op = ALU_AND; end
      OP_ORR: begin reg_we = 1'b1; alu_op = ALU_OR;  end
      OP_LD: begin
        mem_re      = 1'b1;
        wb_from_mem = 1'b1;
        alu_use_imm = 1'b1;
        reg_we      = 1'b1;
      end
      OP_ST: begin
        mem_we        = 1'b1;
        alu_use_imm   = 1'b1;
        rd2_from_dest = 1'b1;
      end
      OP_HLT: halt = 1'b1;
      default: begin
        if (insn[31:24] == OP_CBZ) begin
          alu_op        = ALU_PB;
          rd2_from_dest = 1'b1;
          br_cond       = 1'b1;
        end else if (insn[31:26] == OP_BR) begin
          br_always = 1'b1;
        end
      end
    endcase
  end

  always_comb begin
    AST_ONE_ACTION: assert ($onehot0({mem_re, mem_we, br_cond, br_always, halt})); // R12
    AST_LOAD_WB: assert (!mem_re || (wb_from_mem && reg_we && alu_use_imm && alu_op == ALU_ADD)); // R2
    AST_STORE_NOWB: assert (!mem_we || (!reg_we && rd2_from_dest && alu_use_imm && !wb_from_mem)); // R3
    AST_CBZ_PASSB: assert (!br_cond || (alu_op == ALU_PB && rd2_from_dest && !reg_we)); // R4
    AST_BR_NOWB: assert (!br_always || (!reg_we && !alu_use_imm && alu_op == ALU_ADD)); // R5
    AST_HALT_QUIET: assert (!halt || !(reg_we || rd2_from_dest || alu_use_imm || wb_from_mem)); // R6
  end
endmodule

// File: tb/tb_subset_decoder.sv
module tb_subset_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] insn = 32'h0;
  logic rd2_from_dest, alu_use_imm, wb_from_mem, reg_we, mem_re, mem_we;
  logic br_cond, br_always, halt;
  logic [3:0] alu_op;
  logic [4:0] rs_a, rs_b, rd_t;
  logic [31:0] imm_mem, imm_cbr, imm_jmp;

  subset_decoder dut (
    .insn(insn), .rd2_from_dest(rd2_from_dest), .alu_use_imm(alu_use_imm),
    .wb_from_mem(wb_from_mem), .reg_we(reg_we), .mem_re(mem_re), .mem_we(mem_we),
    .br_cond(br_cond), .br_always(br_always), .halt(halt), .alu_op(alu_op),
    .rs_a(rs_a), .rs_b(rs_b), .rd_t(rd_t),
    .imm_mem(imm_mem), .imm_cbr(imm_cbr), .imm_jmp(imm_jmp)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5677;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s insn=%h actual=%h expected=%h", tag, insn, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [31:0] f, input int n);
    logic [31:0] top;
    top = (f >> (n - 1)) & 32'd1;
    return f - (top << n);
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [12:0] ctl();
    return {rd2_from_dest, alu_use_imm, wb_from_mem, reg_we, mem_re, mem_we,
            br_cond, br_always, halt, alu_op};
  endfunction

  // expected {rd2,imm,wbm,we,re,mwe,bc,ba,halt,alu}
  task automatic expect_ctl(output string tag, output logic [12:0] e);
    logic [10:0] t;
    t = insn[31:21];
    tag = "R7";
    e = {9'b0, 4'd2};
    if      (t == 11'b10001011000) begin tag = "R1"; e = {3'b000, 1'b1, 5'b0, 4'd2}; end
    else if (t == 11'b11001011000) begin tag = "R1"; e = {3'b000, 1'b1, 5'b0, 4'd6}; end
    else if (t == 11'b10001010000) begin tag = "R1"; e = {3'b000, 1'b1, 5'b0, 4'd0}; end
    else if (t == 11'b10101010000) begin tag = "R1"; e = {3'b000, 1'b1, 5'b0, 4'd1}; end
    else if (t == 11'b11111000010) begin tag = "R2"; e = {9'b011110000, 4'd2}; end
    else if (t == 11'b11111000000) begin tag = "R3"; e = {9'b110001000, 4'd2}; end
    else if (t == 11'b11010100010) begin tag = "R6"; e = {9'b000000001, 4'd2}; end
    else if (t[10:3] == 8'b10110100) begin tag = "R4"; e = {9'b100000100, 4'd7}; end
    else if (t[10:5] == 6'b000101)   begin tag = "R5"; e = {9'b000000010, 4'd2}; end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    insn = w;
    @(posedge clk);
    #1;
  endtask

  task automatic full_check();
    string tag;
    logic [12:0] e;
    expect_ctl(tag, e);
    chk(tag, 64'(ctl()), 64'(e));
    chk("R6_halt", 64'(halt), 64'(tag == "R6"));
    chk("R12", 64'($countones({mem_re, mem_we, br_cond, br_always, halt}) <= 1), 64'd1);
    chk("R8", 64'({rs_a, rs_b, rd_t}), 64'({insn[9:5], insn[20:16], insn[4:0]}));
    chk("R9",  64'(imm_mem), 64'(sx(32'(insn[20:12]), 9)));
    chk("R10", 64'(imm_cbr), 64'(sx(32'(insn[23:5]), 19)));
    chk("R11", 64'(imm_jmp), 64'(sx(32'(insn[25:0]), 26)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // reset state: all-zero word is unmatched, R7
    chk("R7_reset", 64'(ctl()), 64'({9'b0, 4'd2}));
    rst_n = 1'b1;
    for (int t = 0; t < 2048; t++) begin
      apply({t[10:0], rnd()[20:0]});
      full_check();
    end
    for (int f = 0; f < 512; f++) begin
      apply({11'b11111000010, f[8:0], rnd()[11:0]});
      chk("R9_sweep", 64'(imm_mem), 64'(sx(32'(f), 9)));
    end
    for (int b = 0; b < 19; b++) begin
      apply({8'b10110100, 19'(1) << b, 5'd3});
      full_check();
      apply({8'b10110100, ~(19'(1) << b), 5'd3});
      full_check();
    end
    for (int b = 0; b < 26; b++) begin
      apply({6'b000101, 26'(1) << b});
      full_check();
      apply({6'b000101, ~(26'(1) << b)});
      full_check();
    end
    apply(32'hFFFF_FFFF); full_check();
    apply(32'h0000_0000); full_check();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule